// File: doc/BRIEF.md
# UART Automatic Flow Control

This block adds automatic flow control to one UART channel. It does not store or serialize any data. On the receive side it watches the fill level of the receive FIFO. It drives the active-low request-to-send output high, which asks the remote end to pause, while the level is at or above a programmed threshold. It drives the output low again once the level falls below that threshold.

The block also sees every received character before that character enters the FIFO. With software flow control enabled, it compares each character with two resume (Xon) codes and two pause (Xoff) codes. A match changes the pause state of the transmitter, and the matched character is not passed on to the FIFO. With special-character detect enabled, the second pause code becomes a marker instead. A marker character is passed on to the FIFO, raises a one-cycle flag, and has no effect on the transmitter.

On the transmit side the block produces a single permit signal for the serializer. The permit combines the synchronized clear-to-send input and the pause state. The permit is frozen while a character is being shifted out, so a pause or resume takes effect only at a character boundary.

Top module: `uart_flowctl`

## Requirements
- R1: While `rst` is high, `rts_n` is 1 and `tx_permit`, `rx_wr` and `spec_hit` are 0.
- R2: With `rts_auto_en` = 1, `rts_n` is 1 one clock after `rx_level` >= `rts_trig`.
- R3: With `rts_auto_en` = 1, `rts_n` is 0 one clock after `rx_level` < `rts_trig`. With `rts_auto_en` = 0, `rts_n` is 0 whatever the level.
- R4: With `cts_auto_en` = 1, a change on `cts_n` reaches `tx_permit` on the third clock edge, after two synchronizer stages. `cts_n` = 1 blocks the permit and `cts_n` = 0 allows it. With `cts_auto_en` = 0, `cts_n` has no effect.
- R5: With `sw_fc_en` = 1, a received character equal to `xoff1` sets the pause state. So does a character equal to `xoff2` while `spec_det_en` = 0. A character equal to `xon1` or `xon2` clears the pause state. `tx_permit` follows the pause state two clocks after the `rx_valid` strobe: it is 0 while paused.
- R6: A character that matches a flow code under R5 produces no `rx_wr`. Every other received character produces `rx_wr` = 1 with `rx_wr_data` equal to the character, one clock after the strobe.
- R7: With `spec_det_en` = 1, a character equal to `xoff2` is written to the FIFO and pulses `spec_hit` for exactly one clock. It does not change the pause state.
- R8: While `tx_busy` = 1, `tx_permit` keeps its value. A pending pause or resume is applied on the first clock after `tx_busy` returns to 0.
- R9: With `sw_fc_en` = 0, no character is treated as a flow code and every character is written. The pause state is cleared, so `tx_permit` is no longer blocked by an earlier Xoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rts_auto_en | input | 1 | Enable automatic request-to-send |
| cts_auto_en | input | 1 | Enable clear-to-send gating of the transmitter |
| sw_fc_en | input | 1 | Enable Xon/Xoff matching |
| spec_det_en | input | 1 | Treat `xoff2` as a marker character |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| rts_trig | input | LVL_W | Threshold at which request-to-send is withdrawn |
| rx_valid | input | 1 | Strobe: a received character is on `rx_data` |
| rx_data | input | DATA_W | Received character |
| xon1 | input | DATA_W | First resume code |
| xon2 | input | DATA_W | Second resume code |
| xoff1 | input | DATA_W | First pause code |
| xoff2 | input | DATA_W | Second pause code and marker code |
| cts_n | input | 1 | Asynchronous active-low clear-to-send |
| tx_busy | input | 1 | A character is being shifted out |
| rts_n | output | 1 | Active-low request-to-send |
| tx_permit | output | 1 | The serializer may start a new character |
| rx_wr | output | 1 | Write strobe to the receive FIFO |
| rx_wr_data | output | DATA_W | Character to write |
| spec_hit | output | 1 | One-cycle pulse on a marker character |

## Verification
The hardest situation to reach is a pause code that arrives while a character is in flight. The pause state has already changed, but the permit must not move until the serializer goes idle. The bench holds `tx_busy` high and strobes `xoff1`. It then checks over two clocks that `tx_permit` is still 1, drops `tx_busy`, and checks that the permit falls on the next edge. The same pattern, with a resume code, covers the release side. A second delicate case is the clear-to-send path. Here the bench samples after two edges, when nothing may have changed yet, and again after the third edge, when the change must be visible.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    MK_NONE = 2'd0,
    MK_XON  = 2'd1,
    MK_XOFF = 2'd2,
    MK_SPEC = 2'd3
  } match_kind_t;
endpackage

// File: rtl/fc_rts_ctrl.sv
module fc_rts_ctrl #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_en,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] trig,
  output logic             rts_n
);
  logic at_trig;
  assign at_trig = (level >= trig);

  always_ff @(posedge clk) begin
    if (rst) rts_n <= 1'b1;
    else     rts_n <= auto_en & at_trig;
  end
endmodule

// File: rtl/fc_char_match.sv
module fc_char_match
  import fc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_en,
  input  logic              spec_en,
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] on1,
  input  logic [DATA_W-1:0] on2,
  input  logic [DATA_W-1:0] off1,
  input  logic [DATA_W-1:0] off2,
  output logic              wr,
  output logic [DATA_W-1:0] wr_data,
  output logic              spec,
  output logic              paused
);
  match_kind_t kind;

  always_comb begin
    kind = MK_NONE;
    if (spec_en && data == off2)                          kind = MK_SPEC;
    else if (sw_en && (data == off1 || data == off2))     kind = MK_XOFF;
    else if (sw_en && (data == on1 || data == on2))       kind = MK_XON;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr      <= 1'b0;
      wr_data <= '0;
      spec    <= 1'b0;
      paused  <= 1'b0;
    end else begin
      wr   <= valid && (kind == MK_NONE || kind == MK_SPEC);
      spec <= valid && (kind == MK_SPEC);
      if (valid) wr_data <= data;
      if (!sw_en)                          paused <= 1'b0;
      else if (valid && kind == MK_XOFF)   paused <= 1'b1;
      else if (valid && kind == MK_XON)    paused <= 1'b0;
    end
  end
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_en,
  input  logic cts_n,
  input  logic sw_en,
  input  logic paused,
  input  logic busy,
  output logic permit
);
  localparam int LAST = SYNC_STAGES - 1;
  logic [SYNC_STAGES-1:0] sync_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b1;
          else     sync_q[0] <= cts_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  logic allow;
  assign allow = !(cts_en && sync_q[LAST]) && !(sw_en && paused);

  always_ff @(posedge clk) begin
    if (rst)        permit <= 1'b0;
    else if (!busy) permit <= allow;
  end
endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl #(
  parameter int LVL_W       = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rts_auto_en,
  input  logic              cts_auto_en,
  input  logic              sw_fc_en,
  input  logic              spec_det_en,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  rts_trig,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] xon1,
  input  logic [DATA_W-1:0] xon2,
  input  logic [DATA_W-1:0] xoff1,
  input  logic [DATA_W-1:0] xoff2,
  input  logic              cts_n,
  input  logic              tx_busy,
  output logic              rts_n,
  output logic              tx_permit,
  output logic              rx_wr,
  output logic [DATA_W-1:0] rx_wr_data,
  output logic              spec_hit
);
  logic paused;

  fc_rts_ctrl #(.LVL_W(LVL_W)) u_rts (
    .clk(clk), .rst(rst), .auto_en(rts_auto_en),
    .level(rx_level), .trig(rts_trig), .rts_n(rts_n)
  );

  fc_char_match #(.DATA_W(DATA_W)) u_match (
    .clk(clk), .rst(rst), .sw_en(sw_fc_en), .spec_en(spec_det_en),
    .valid(rx_valid), .data(rx_data),
    .on1(xon1), .on2(xon2), .off1(xoff1), .off2(xoff2),
    .wr(rx_wr), .wr_data(rx_wr_data), .spec(spec_hit), .paused(paused)
  );

  fc_tx_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk(clk), .rst(rst), .cts_en(cts_auto_en), .cts_n(cts_n),
    .sw_en(sw_fc_en), .paused(paused), .busy(tx_busy), .permit(tx_permit)
  );
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int LVL_W  = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rts_auto_en,
  input logic              sw_fc_en,
  input logic              spec_det_en,
  input logic [LVL_W-1:0]  rx_level,
  input logic [LVL_W-1:0]  rts_trig,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic [DATA_W-1:0] xon1,
  input logic [DATA_W-1:0] xon2,
  input logic [DATA_W-1:0] xoff1,
  input logic [DATA_W-1:0] xoff2,
  input logic              tx_busy,
  input logic              rts_n,
  input logic              tx_permit,
  input logic              rx_wr,
  input logic              spec_hit
);
  AST_RTS_WITHDRAW: assert property (@(posedge clk) disable iff (rst)
    (rts_auto_en && rx_level >= rts_trig) |=> rts_n); // R2
  AST_RTS_REQUEST: assert property (@(posedge clk) disable iff (rst)
    (!rts_auto_en || rx_level < rts_trig) |=> !rts_n); // R3
  AST_FLOW_NOT_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && sw_fc_en && (rx_data == xoff1 || rx_data == xon1 || rx_data == xon2 ||
     (rx_data == xoff2 && !spec_det_en))) |=> !rx_wr); // R6
  AST_SPEC_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && spec_det_en && rx_data == xoff2) |=> (spec_hit && rx_wr)); // R7
  AST_HOLD_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> $stable(tx_permit)); // R8
  AST_PLAIN_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !sw_fc_en && !spec_det_en) |=> (rx_wr && !spec_hit)); // R9
endmodule

bind uart_flowctl fc_checker #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rts_auto_en(rts_auto_en), .sw_fc_en(sw_fc_en),
  .spec_det_en(spec_det_en), .rx_level(rx_level), .rts_trig(rts_trig),
  .rx_valid(rx_valid), .rx_data(rx_data), .xon1(xon1), .xon2(xon2),
  .xoff1(xoff1), .xoff2(xoff2), .tx_busy(tx_busy), .rts_n(rts_n),
  .tx_permit(tx_permit), .rx_wr(rx_wr), .spec_hit(spec_hit)
);

// File: tb/sim_uart_flowctl.sv
module sim_uart_flowctl;
  localparam int LVL_W = 5;
  localparam int DW    = 8;

  logic clk = 1'b0;
  logic rst;
  logic rts_auto_en, cts_auto_en, sw_fc_en, spec_det_en;
  logic [LVL_W-1:0] rx_level, rts_trig;
  logic rx_valid;
  logic [DW-1:0] rx_data, xon1, xon2, xoff1, xoff2;
  logic cts_n, tx_busy;
  logic rts_n, tx_permit, rx_wr, spec_hit;
  logic [DW-1:0] rx_wr_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  uart_flowctl #(.LVL_W(LVL_W), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .rts_auto_en(rts_auto_en), .cts_auto_en(cts_auto_en),
    .sw_fc_en(sw_fc_en), .spec_det_en(spec_det_en), .rx_level(rx_level),
    .rts_trig(rts_trig), .rx_valid(rx_valid), .rx_data(rx_data),
    .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
    .cts_n(cts_n), .tx_busy(tx_busy), .rts_n(rts_n), .tx_permit(tx_permit),
    .rx_wr(rx_wr), .rx_wr_data(rx_wr_data), .spec_hit(spec_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Strobe one character, sample the write path one clock later.
  task automatic send(input logic [DW-1:0] c);
    rx_valid = 1'b1;
    rx_data  = c;
    tick(1);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(2);
    check("R1 rts_n", rts_n, 1);
    check("R1 tx_permit", tx_permit, 0);
    check("R1 rx_wr", rx_wr, 0);
    check("R1 spec_hit", spec_hit, 0);
    rst = 1'b0;
    tick(1);
    check("R4 permit with gating off", tx_permit, 1);
  endtask

  task automatic t_rts();
    rts_auto_en = 1'b1; rts_trig = 5'd8;
    rx_level = 5'd7;  tick(1); check("R3 below trig", rts_n, 0);
    rx_level = 5'd8;  tick(1); check("R2 at trig", rts_n, 1);
    rx_level = 5'd16; tick(1); check("R2 above trig", rts_n, 1);
    rx_level = 5'd7;  tick(1); check("R3 back below", rts_n, 0);
    rx_level = 5'd16; rts_auto_en = 1'b0;
    tick(1); check("R3 auto off", rts_n, 0);
    rx_level = 5'd0;
  endtask

  task automatic t_cts();
    cts_auto_en = 1'b1; cts_n = 1'b0;
    tick(3); check("R4 cts asserted", tx_permit, 1);
    cts_n = 1'b1;
    tick(2); check("R4 not yet through sync", tx_permit, 1);
    tick(1); check("R4 cts deasserted", tx_permit, 0);
    cts_n = 1'b0;
    tick(3); check("R4 cts back", tx_permit, 1);
    cts_n = 1'b1;
    tick(3); check("R4 blocked again", tx_permit, 0);
    cts_auto_en = 1'b0;
    tick(1); check("R4 cts ignored when off", tx_permit, 1);
    cts_n = 1'b0;
  endtask

  task automatic t_swfc();
    sw_fc_en = 1'b1;
    send(xoff1);
    check("R6 xoff1 not written", rx_wr, 0);
    tick(1); check("R5 xoff1 pauses", tx_permit, 0);
    send(8'h41);
    check("R6 plain written", rx_wr, 1);
    check("R6 plain data", rx_wr_data, 8'h41);
    tick(1); check("R5 still paused", tx_permit, 0);
    send(xon2);
    check("R6 xon2 not written", rx_wr, 0);
    tick(1); check("R5 xon2 resumes", tx_permit, 1);
    send(xoff2);
    check("R6 xoff2 not written", rx_wr, 0);
    tick(1); check("R5 xoff2 pauses", tx_permit, 0);
    send(xon1);
    tick(1); check("R5 xon1 resumes", tx_permit, 1);
  endtask

  task automatic t_spec();
    spec_det_en = 1'b1;
    send(xoff2);
    check("R7 marker written", rx_wr, 1);
    check("R7 marker data", rx_wr_data, xoff2);
    check("R7 flag raised", spec_hit, 1);
    tick(1);
    check("R7 flag one cycle", spec_hit, 0);
    check("R7 no pause", tx_permit, 1);
    spec_det_en = 1'b0;
  endtask

  task automatic t_busy();
    tx_busy = 1'b1;
    send(xoff1);
    tick(1); check("R8 held while busy", tx_permit, 1);
    tx_busy = 1'b0;
    tick(1); check("R8 pause after boundary", tx_permit, 0);
    tx_busy = 1'b1;
    send(xon1);
    tick(1); check("R8 held paused while busy", tx_permit, 0);
    tx_busy = 1'b0;
    tick(1); check("R8 resume after boundary", tx_permit, 1);
  endtask

  task automatic t_swoff();
    send(xoff1);
    tick(1); check("R5 paused before disable", tx_permit, 0);
    sw_fc_en = 1'b0;
    send(xoff1);
    check("R9 xoff written when off", rx_wr, 1);
    tick(1); check("R9 pause cleared", tx_permit, 1);
    send(xon1);
    check("R9 xon written when off", rx_wr, 1);
  endtask

  initial begin
    rst = 1'b1; rts_auto_en = 0; cts_auto_en = 0; sw_fc_en = 0; spec_det_en = 0;
    rx_level = '0; rts_trig = '0; rx_valid = 0; rx_data = '0;
    xon1 = 8'h11; xon2 = 8'h13; xoff1 = 8'h19; xoff2 = 8'h93;
    cts_n = 1'b0; tx_busy = 1'b0;
    @(negedge clk);
    t_reset();
    t_rts();
    t_cts();
    t_swfc();
    t_spec();
    t_busy();
    t_swoff();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule